// File: doc/BRIEF.md
# HDR Metadata Packet Merger

This block sits on an auxiliary packet stream clocked at link speed, between an upstream packet source and a downstream sink. It forwards upstream packets unchanged. Once per video frame, on the rising edge of a vertical sync input that is already synchronous to the link clock, it builds one dynamic-range metadata InfoFrame. The InfoFrame is made from three header bytes, a computed checksum and a 28-byte payload bundle, and the block merges it into the output stream between upstream packets.

When filtering is enabled, the block also removes any upstream packet that carries the same InfoFrame type. In that case only the locally supplied metadata reaches the sink. Clearing the filter enable lets upstream metadata packets pass through. Clearing the insert enable stops local packets, which leaves a plain retransmit path.

The local packet is four 72-bit beats. Beat k carries, in byte lane j (bits [8j+7:8j], j = 0..7), byte 8k+j of this sequence: type code, version, length, checksum, then payload bytes 1 to 28. Bits [71:64] are zero. Payload byte N sits at bundle bits [8N-1:8N-8]. Byte 1 holds the 3-bit transfer function code and byte 2 holds the 3-bit descriptor id. Bytes 3 to 26 hold twelve 16-bit metadata fields, each low byte first, in this order: the three primaries as x/y pairs, white point x/y, max and min mastering luminance, max content light level, and max frame-average light level. Bytes 27 and 28 are reserved.

Top module: `aux_hdr_merge`

## Requirements
- R1: After reset no insertion is pending, so with no upstream valid the output valid is low.
- R2: An upstream packet whose first-beat byte [7:0] is not the metadata type (0x87) is forwarded beat for beat with unchanged data, start and end flags, and output channel 0.
- R3: A vsync rising edge with insertion enabled produces exactly one local packet of four beats. It is sent on channel 1 with start on beat 0, end on beat 3, and the byte layout given above, using header 0x87, 0x01, 26.
- R4: The checksum byte (beat 0 lane 3) makes the 32 packet bytes sum to 0 modulo 256.
- R5: A pending insertion never interrupts an upstream packet in progress. It starts after that packet's end beat is accepted, and it goes before an upstream packet whose start beat is already waiting.
- R6: Further vsync edges while an insertion is still pending add no second packet.
- R7: With filtering enabled, an upstream packet whose start beat has byte [7:0] equal to 0x87 is accepted in full with upstream ready held high, even while the sink stalls, and no beat of it reaches the output.
- R8: With filtering disabled, upstream packets of type 0x87 are forwarded like any other packet.
- R9: With insertion disabled, a vsync edge produces no local packet.
- R10: While the sink holds ready low, a local beat keeps its valid and data stable, upstream ready stays low, and a forwarded upstream beat sees upstream ready equal to the sink ready.
- R11: Holding vsync high for many cycles triggers only one insertion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link-speed clock |
| rst | input | 1 | Synchronous reset, active high |
| vsync | input | 1 | Vertical sync, link-clock synchronous |
| insertEn | input | 1 | Enables local InfoFrame insertion |
| filterEn | input | 1 | Enables removal of upstream metadata packets |
| payload | input | 224 | Metadata payload bundle, byte N at [8N-1:8N-8] |
| upData | input | 72 | Upstream beat data |
| upValid | input | 1 | Upstream beat valid |
| upReady | output | 1 | Ready returned to upstream |
| upSop | input | 1 | Upstream start of packet |
| upEop | input | 1 | Upstream end of packet |
| outData | output | 72 | Output beat data |
| outValid | output | 1 | Output beat valid |
| outReady | input | 1 | Ready from the sink |
| outSop | output | 1 | Output start of packet |
| outEop | output | 1 | Output end of packet |
| outChan | output | 11 | 1 for the local packet, 0 for forwarded beats |

## Verification
The bench aims at the arbitration corners. A vsync edge landing mid-packet must wait for the upstream end beat; a design that preempted would split the upstream packet. An upstream start beat already waiting when that packet ends must lose to the pending insertion; a design that ignored priority would send it first. Two edges during one wait must give one packet, not two. A filtered packet is pushed in while the sink stalls; a design that tied ready to the sink would hang. A stalled local beat is sampled over several cycles to catch a counter that advances without a handshake, and the checksum is summed over the captured bytes rather than compared against a copy of the formula.

// File: rtl/aux_hdr_pkg.sv
package aux_hdr_pkg;
  localparam int IDX_W = 4;

  typedef struct packed {
    logic             selLocal;  // local packet owns the output
    logic [IDX_W-1:0] beatIdx;   // local beat being presented
  } strobes_t;
endpackage

// File: rtl/aux_hdr_ctrl.sv
module aux_hdr_ctrl
  import aux_hdr_pkg::*;
#(
  parameter int NUM_BEATS = 4
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     vsync,
  input  logic     insertEn,
  input  logic     filterEn,
  input  logic     upValid,
  input  logic     upSop,
  input  logic     upEop,
  input  logic     upIsHdr,
  input  logic     outReady,
  output logic     upReady,
  output logic     outValid,
  output strobes_t ctl
);
  typedef enum logic [1:0] {S_IDLE, S_UP, S_LOC} state_t;

  state_t           state;
  logic             vsyncQ, pending, dropQ;
  logic [IDX_W-1:0] beatCnt;
  logic             selLocal, dropNow, upFire, locFire, lastBeat;

  always_comb begin
    selLocal = (state == S_LOC) || (state == S_IDLE && pending);
    dropNow  = (state == S_UP) ? dropQ : (filterEn && upSop && upIsHdr);
    upReady  = !selLocal && (dropNow || outReady);
    outValid = selLocal || (upValid && !dropNow);
    upFire   = upValid && upReady;
    locFire  = selLocal && outReady;
    lastBeat = (beatCnt == IDX_W'(NUM_BEATS - 1));
    ctl.selLocal = selLocal;
    ctl.beatIdx  = beatCnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      vsyncQ  <= 1'b0;
      pending <= 1'b0;
      dropQ   <= 1'b0;
      beatCnt <= '0;
    end else begin
      vsyncQ <= vsync;
      if (insertEn && vsync && !vsyncQ) pending <= 1'b1;
      else if (locFire && beatCnt == '0) pending <= 1'b0;

      unique case (state)
        S_IDLE: begin
          if (selLocal) begin
            if (locFire) begin
              beatCnt <= lastBeat ? '0 : beatCnt + 1'b1;
              state   <= lastBeat ? S_IDLE : S_LOC;
            end
          end else if (upFire && upSop && !upEop) begin
            state <= S_UP;
            dropQ <= dropNow;
          end
        end
        S_UP: if (upFire && upEop) state <= S_IDLE;
        S_LOC: if (locFire) begin
          beatCnt <= lastBeat ? '0 : beatCnt + 1'b1;
          if (lastBeat) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/aux_hdr_dp.sv
module aux_hdr_dp
  import aux_hdr_pkg::*;
#(
  parameter int          DATA_W     = 72,
  parameter int          CHAN_W     = 11,
  parameter int          PB_BYTES   = 28,
  parameter int          LANES      = 8,
  parameter int          NUM_BEATS  = 4,
  parameter logic [7:0]  HDR_TYPE   = 8'h87,
  parameter logic [7:0]  HDR_VER    = 8'h01,
  parameter logic [7:0]  HDR_LEN    = 8'd26,
  parameter int          LOCAL_CHAN = 1
) (
  input  strobes_t            ctl,
  input  logic [8*PB_BYTES-1:0] payload,
  input  logic [DATA_W-1:0]   upData,
  input  logic                upSop,
  input  logic                upEop,
  output logic                upIsHdr,
  output logic [DATA_W-1:0]   outData,
  output logic                outSop,
  output logic                outEop,
  output logic [CHAN_W-1:0]   outChan
);
  localparam int SLOTS = NUM_BEATS * LANES;

  logic [7:0]        seqB [SLOTS];
  logic [7:0]        csum;
  logic [DATA_W-1:0] locWord;

  always_comb begin
    csum = 8'(HDR_TYPE + HDR_VER + HDR_LEN);
    for (int n = 0; n < PB_BYTES; n++) csum = csum + payload[8*n +: 8];
    csum = 8'(-csum);
  end

  always_comb begin
    for (int s = 0; s < SLOTS; s++) seqB[s] = 8'h00;
    seqB[0] = HDR_TYPE;
    seqB[1] = HDR_VER;
    seqB[2] = HDR_LEN;
    seqB[3] = csum;
    for (int n = 0; n < PB_BYTES; n++) seqB[4 + n] = payload[8*n +: 8];
  end

  always_comb begin
    locWord = '0;
    for (int j = 0; j < LANES; j++)
      locWord[8*j +: 8] = seqB[int'(ctl.beatIdx) * LANES + j];
  end

  assign upIsHdr = (upData[7:0] == HDR_TYPE);
  assign outData = ctl.selLocal ? locWord : upData;
  assign outSop  = ctl.selLocal ? (ctl.beatIdx == '0) : upSop;
  assign outEop  = ctl.selLocal ? (int'(ctl.beatIdx) == NUM_BEATS - 1) : upEop;
  assign outChan = ctl.selLocal ? CHAN_W'(LOCAL_CHAN) : '0;
endmodule

// File: rtl/aux_hdr_merge.sv
module aux_hdr_merge
  import aux_hdr_pkg::*;
#(
  parameter int         DATA_W     = 72,
  parameter int         CHAN_W     = 11,
  parameter int         PB_BYTES   = 28,
  parameter logic [7:0] HDR_TYPE   = 8'h87,
  parameter logic [7:0] HDR_VER    = 8'h01,
  parameter logic [7:0] HDR_LEN    = 8'd26,
  parameter int         LOCAL_CHAN = 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  vsync,
  input  logic                  insertEn,
  input  logic                  filterEn,
  input  logic [8*PB_BYTES-1:0] payload,
  input  logic [DATA_W-1:0]     upData,
  input  logic                  upValid,
  output logic                  upReady,
  input  logic                  upSop,
  input  logic                  upEop,
  output logic [DATA_W-1:0]     outData,
  output logic                  outValid,
  input  logic                  outReady,
  output logic                  outSop,
  output logic                  outEop,
  output logic [CHAN_W-1:0]     outChan
);
  localparam int LANES     = 8;
  localparam int TOTAL_B   = 4 + PB_BYTES;
  localparam int NUM_BEATS = (TOTAL_B + LANES - 1) / LANES;

  strobes_t ctl;
  logic     upIsHdr;

  aux_hdr_ctrl #(.NUM_BEATS(NUM_BEATS)) u_ctrl (
    .clk(clk), .rst(rst), .vsync(vsync), .insertEn(insertEn),
    .filterEn(filterEn), .upValid(upValid), .upSop(upSop), .upEop(upEop),
    .upIsHdr(upIsHdr), .outReady(outReady), .upReady(upReady),
    .outValid(outValid), .ctl(ctl)
  );

  aux_hdr_dp #(
    .DATA_W(DATA_W), .CHAN_W(CHAN_W), .PB_BYTES(PB_BYTES), .LANES(LANES),
    .NUM_BEATS(NUM_BEATS), .HDR_TYPE(HDR_TYPE), .HDR_VER(HDR_VER),
    .HDR_LEN(HDR_LEN), .LOCAL_CHAN(LOCAL_CHAN)
  ) u_dp (
    .ctl(ctl), .payload(payload), .upData(upData), .upSop(upSop),
    .upEop(upEop), .upIsHdr(upIsHdr), .outData(outData), .outSop(outSop),
    .outEop(outEop), .outChan(outChan)
  );
endmodule

// File: rtl/aux_hdr_merge_chk.sv
module aux_hdr_merge_chk #(
  parameter int         DATA_W     = 72,
  parameter int         CHAN_W     = 11,
  parameter logic [7:0] HDR_TYPE   = 8'h87,
  parameter int         LOCAL_CHAN = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              filterEn,
  input logic              upReady,
  input logic              outValid,
  input logic              outReady,
  input logic              outSop,
  input logic [DATA_W-1:0] outData,
  input logic [CHAN_W-1:0] outChan,
  input logic              selLocal
);
  // R10: a stalled local beat keeps valid and data
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady && selLocal) |=> (outValid && selLocal && $stable(outData)));

  // R10: forwarded beats see the sink's ready
  p_ready_pass_r10: assert property (@(posedge clk) disable iff (rst)
    (outValid && outChan == '0) |-> (upReady == outReady));

  // R5: upstream is stalled while the local packet owns the output
  p_no_preempt_r5: assert property (@(posedge clk) disable iff (rst)
    selLocal |-> !upReady);

  // R7: no forwarded packet of the metadata type while filtering
  p_filtered_r7: assert property (@(posedge clk) disable iff (rst)
    (outValid && outSop && outChan == '0 && filterEn) |-> (outData[7:0] != HDR_TYPE));

  // R3: local packet starts with the type byte on its own channel
  p_local_head_r3: assert property (@(posedge clk) disable iff (rst)
    (outValid && outSop && outChan == CHAN_W'(LOCAL_CHAN)) |-> (outData[7:0] == HDR_TYPE));
endmodule

bind aux_hdr_merge aux_hdr_merge_chk #(
  .DATA_W(DATA_W), .CHAN_W(CHAN_W), .HDR_TYPE(HDR_TYPE), .LOCAL_CHAN(LOCAL_CHAN)
) u_chk (
  .clk(clk), .rst(rst), .filterEn(filterEn), .upReady(upReady),
  .outValid(outValid), .outReady(outReady), .outSop(outSop),
  .outData(outData), .outChan(outChan), .selLocal(ctl.selLocal)
);

// File: tb/aux_hdr_merge_test.sv
`timescale 1ns/1ps
module aux_hdr_merge_test;
  logic         clk = 0, rst = 1, vsync = 0, insertEn = 1, filterEn = 1;
  logic [223:0] payload;
  logic [71:0]  upData = '0;
  logic         upValid = 0, upSop = 0, upEop = 0, outReady = 1;
  logic         upReady, outValid, outSop, outEop;
  logic [71:0]  outData;
  logic [10:0]  outChan;

  int errors = 0, checks = 0, capN = 0;
  logic [71:0] capData [256];
  logic        capSop [256], capEop [256];
  logic [10:0] capChan [256];

  always #2 clk = ~clk;

  aux_hdr_merge uut (
    .clk(clk), .rst(rst), .vsync(vsync), .insertEn(insertEn), .filterEn(filterEn),
    .payload(payload), .upData(upData), .upValid(upValid), .upReady(upReady),
    .upSop(upSop), .upEop(upEop), .outData(outData), .outValid(outValid),
    .outReady(outReady), .outSop(outSop), .outEop(outEop), .outChan(outChan)
  );

  always @(negedge clk)
    if (!rst && outValid && outReady && capN < 256) begin
      capData[capN] <= outData; capSop[capN] <= outSop;
      capEop[capN] <= outEop;  capChan[capN] <= outChan;
      capN <= capN + 1;
    end

  task automatic check(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  function automatic logic [7:0] seqByte(input int s);
    logic [7:0] sum;
    sum = 8'h87 + 8'h01 + 8'd26;
    for (int n = 0; n < 28; n++) sum = sum + payload[8*n +: 8];
    if (s == 0) return 8'h87;
    if (s == 1) return 8'h01;
    if (s == 2) return 8'd26;
    if (s == 3) return 8'(-sum);
    return payload[8*(s-4) +: 8];
  endfunction

  function automatic logic [71:0] expLoc(input int k);
    logic [71:0] w = '0;
    for (int j = 0; j < 8; j++) w[8*j +: 8] = seqByte(8*k + j);
    return w;
  endfunction

  function automatic logic [71:0] upWord(input logic [7:0] typ, input logic [7:0] tag, input int i);
    return {16'h0, tag, 8'(i), 32'hA5A5_0000, typ};
  endfunction

  task automatic sendBeat(input logic [71:0] d, input logic s, input logic e);
    @(posedge clk); #1;
    upValid = 1; upData = d; upSop = s; upEop = e;
    @(negedge clk);
    while (!upReady) @(negedge clk);
  endtask

  task automatic sendPkt(input logic [7:0] typ, input int n, input logic [7:0] tag);
    for (int i = 0; i < n; i++) sendBeat(upWord(typ, tag, i), i == 0, i == n - 1);
  endtask

  task automatic idleUp();
    @(posedge clk); #1; upValid = 0; upSop = 0; upEop = 0;
  endtask

  task automatic pulseVsync();
    @(posedge clk); #1 vsync = 1;
    @(posedge clk); #1 vsync = 0;
  endtask

  task automatic checkLocal(input int b, input string tag);
    logic [7:0] sum = 0;
    for (int k = 0; k < 4; k++) begin
      check(capData[b+k] == expLoc(k) && capChan[b+k] == 11'd1 &&
            capSop[b+k] == (k == 0) && capEop[b+k] == (k == 3), tag, capData[b+k], expLoc(k));
      for (int j = 0; j < 8; j++) sum = sum + capData[b+k][8*j +: 8];
    end
    check(sum == 8'h00, "R4 checksum sum", 72'(sum), 72'h0);
  endtask

  // {filterEn, type, forwarded}
  localparam logic [9:0] VEC [5] = '{
    {1'b1, 8'h82, 1'b1}, {1'b1, 8'h87, 1'b0}, {1'b0, 8'h87, 1'b1},
    {1'b0, 8'h84, 1'b1}, {1'b1, 8'h87, 1'b0}
  };

  initial begin
    int b;
    logic [71:0] held;
    for (int n = 0; n < 28; n++) payload[8*n +: 8] = 8'(n * 37 + 11);
    repeat (4) @(posedge clk); #1 rst = 0;
    @(negedge clk);
    check(outValid == 0, "R1 reset valid", 72'(outValid), 72'h0);

    // Table: forwarding and filtering (R2, R7, R8)
    for (int v = 0; v < 5; v++) begin
      b = capN;
      filterEn = VEC[v][9];
      sendPkt(VEC[v][8:1], 3, 8'(v));
      idleUp();
      repeat (3) @(negedge clk);
      if (VEC[v][0]) begin
        check(capN - b == 3, VEC[v][9] ? "R2 forward count" : "R8 forward count", 72'(capN - b), 72'd3);
        for (int i = 0; i < 3; i++)
          check(capData[b+i] == upWord(VEC[v][8:1], 8'(v), i) && capChan[b+i] == 0 &&
                capSop[b+i] == (i == 0) && capEop[b+i] == (i == 2),
                "R2 R8 forwarded beat", capData[b+i], upWord(VEC[v][8:1], 8'(v), i));
      end else
        check(capN - b == 0, "R7 dropped", 72'(capN - b), 72'h0);
    end

    // R7: drop proceeds while the sink stalls
    filterEn = 1; b = capN;
    @(posedge clk); #1 outReady = 0;
    sendPkt(8'h87, 4, 8'h55);
    idleUp();
    @(negedge clk);
    check(capN == b && outValid == 0, "R7 drop under stall", 72'(capN - b), 72'h0);
    @(posedge clk); #1 outReady = 1;

    // R3, R4: basic insertion
    b = capN;
    pulseVsync();
    repeat (10) @(negedge clk);
    check(capN - b == 4, "R3 local count", 72'(capN - b), 72'd4);
    checkLocal(b, "R3 local beat");

    // R5, R6: edges during an upstream packet, next packet waiting
    b = capN;
    fork
      begin sendPkt(8'h81, 6, 8'hA1); sendPkt(8'h83, 2, 8'hB2); idleUp(); end
      begin repeat (2) @(posedge clk); pulseVsync(); pulseVsync(); end
    join
    repeat (10) @(negedge clk);
    check(capN - b == 12, "R6 single insertion", 72'(capN - b), 72'd12);
    for (int i = 0; i < 6; i++)
      check(capData[b+i] == upWord(8'h81, 8'hA1, i) && capChan[b+i] == 0,
            "R5 upstream intact", capData[b+i], upWord(8'h81, 8'hA1, i));
    checkLocal(b + 6, "R5 local after eop");
    check(capData[b+10] == upWord(8'h83, 8'hB2, 0) && capSop[b+10],
          "R5 next packet after local", capData[b+10], upWord(8'h83, 8'hB2, 0));

    // R9: insertion disabled
    insertEn = 0; b = capN;
    pulseVsync();
    repeat (10) @(negedge clk);
    check(capN - b == 0, "R9 no insertion", 72'(capN - b), 72'h0);
    insertEn = 1;

    // R11: long vsync high
    b = capN;
    @(posedge clk); #1 vsync = 1;
    repeat (20) @(posedge clk);
    #1 vsync = 0;
    repeat (6) @(negedge clk);
    check(capN - b == 4, "R11 one insertion", 72'(capN - b), 72'd4);

    // R10: local beat stalled, upstream waiting
    b = capN;
    @(posedge clk); #1 outReady = 0;
    upValid = 1; upData = upWord(8'h81, 8'hC3, 0); upSop = 1; upEop = 1;
    pulseVsync();
    repeat (2) @(negedge clk);
    held = outData;
    check(outValid && held == expLoc(0) && upReady == 0, "R10 stalled local", held, expLoc(0));
    repeat (3) @(negedge clk);
    check(outValid && outData == held && upReady == 0, "R10 stable", outData, held);
    @(posedge clk); #1 outReady = 1;
    @(negedge clk);
    while (!(upReady && outChan == 0)) @(negedge clk);
    idleUp();
    repeat (3) @(negedge clk);
    check(capN - b == 5, "R10 all beats", 72'(capN - b), 72'd5);
    checkLocal(b, "R10 local intact");

    // R10: forwarded beat follows sink ready
    @(posedge clk); #1 outReady = 0;
    upValid = 1; upData = upWord(8'h85, 8'hD4, 0); upSop = 1; upEop = 1;
    @(negedge clk);
    check(upReady == 0 && outValid == 1, "R10 ready follows sink", 72'(upReady), 72'h0);
    @(posedge clk); #1 outReady = 1;
    @(negedge clk);
    check(upReady == 1, "R10 ready released", 72'(upReady), 72'h1);
    idleUp();
    repeat (2) @(negedge clk);

    summary();
  end
endmodule